// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port: a transmitter and a receiver that share one power gate and one set of character settings. Each direction has its own enable. Software writes a character into a one-entry transmit holding register. A flag shows that the register is occupied until the shift engine takes the character. Received characters land in a one-entry receive buffer. Three sticky error flags travel with that buffer and report parity, framing and overrun errors.

Bit timing comes from an external baud tick at sixteen times the bit rate. The block counts ticks and has no divider of its own. The character settings are parity mode, 7 or 8 data bits, and one or two transmitted stop bits. The settings are level inputs. The expected use is to change them only while both enables are low. Each enable takes effect one clock after it is raised. To shut down, software clears the enable first and then the power bit. Clearing power returns both engines to idle.

Top module: `uart_xcvr`

## Requirements
- R1: During and right after reset, `tx_line` is 1, and `tx_full`, `rx_valid` and all three error flags are 0.
- R2: A write strobe is accepted only if `cfg_power` and `cfg_tx_en` are both 1 and `cfg_tx_en` was also 1 on the previous clock. A write in the first enabled clock is dropped, and `tx_full` stays 0.
- R3: An accepted write sets `tx_full` at the next edge. `tx_full` clears on the edge where the shift engine loads the character. A write while `tx_full` is 1 is dropped and never sent.
- R4: A transmitted frame has these fields, in order: a 0 start bit, 7 or 8 data bits sent LSB first (`cfg_len8`=1 selects 8), an optional parity bit, and 1 or 2 stop bits at 1 (`cfg_stop2`=1 selects 2). Each bit lasts 16 baud ticks. The line idles at 1.
- R5: `cfg_parity` codes are as follows. 00 means no parity bit. 01 means the parity bit is always 0. 10 means odd parity, so data plus parity hold an odd count of ones. 11 means even parity.
- R6: The receiver accepts a start bit only if the line is still low 8 ticks after the falling edge. It samples each later bit 16 ticks apart. It stores the character with `rx_valid`=1, and the 7-bit mode gives bit 7 = 0. A `rd_data_stb` pulse clears `rx_valid`.
- R7: `err_parity` is set for a stored character whose parity bit differs from the one mode R5 would send.
- R8: `err_frame` is set when the first stop bit is sampled low. Only that one stop bit is checked, even with `cfg_stop2`=1. A new start bit may follow right after a single stop bit.
- R9: If a character completes while `rx_valid` is 1 and no read is pending, the new character is discarded. `rx_data` keeps the old value and `err_overrun` is set.
- R10: Storing a character replaces `err_parity` and `err_frame` with that character's values. A `rd_err_stb` pulse clears all three flags.
- R11: If `cfg_rx_en` rises while `rx_line` is already low, the receiver takes the low level as a start bit and receives a frame.
- R12: When `cfg_power` is 0, `tx_line` is 1 and `tx_full` is 0 from the next clock on. After power returns, R2's one-clock latency applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock pulse at 16x bit rate |
| cfg_power | input | 1 | Power gate for both directions |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_parity | input | 2 | Parity mode (R5) |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_stop2 | input | 1 | 1 = two transmitted stop bits |
| wr_stb | input | 1 | Write transmit holding register |
| wr_data | input | 8 | Character to send |
| tx_full | output | 1 | Transmit holding register occupied |
| tx_line | output | 1 | Serial output |
| rx_line | input | 1 | Serial input (asynchronous) |
| rd_err_stb | input | 1 | Read of error flags, clears them |
| rd_data_stb | input | 1 | Read of receive buffer |
| rx_valid | output | 1 | Receive buffer holds unread data |
| rx_data | output | 8 | Receive buffer |
| err_parity | output | 1 | Parity error of buffered character |
| err_frame | output | 1 | Framing error of buffered character |
| err_overrun | output | 1 | A character was lost |

## Verification
The bench writes in the same clock that enables the transmitter. A design without the latency would send that character. It also writes a third character while the holding register is full. A design that overwrote the register would send the third character instead of the second. It sends frames of one stop bit back to back with two stop bits configured. A receiver that checked both stop bits would flag a framing error or lose the second frame. Unread characters pile up to force an overrun, and a design that overwrote the buffer shows the newer byte. Finally, the bench raises the receive enable on a low line and checks that a correct frame comes in.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  typedef enum logic [1:0] {
    RX_IDLE, RX_START, RX_BITS, RX_STOP
  } rx_state_e;

  // parity bit the transmitter appends for a given mode and character
  function automatic logic par_bit(par_mode_e m, logic [DATA_W-1:0] d, logic len8);
    logic x;
    x = ^(len8 ? d : {1'b0, d[DATA_W-2:0]});
    case (m)
      PAR_ODD:  return ~x;
      PAR_EVEN: return x;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uart_xcvr_tx.sv
module uart_xcvr_tx
  import uart_xcvr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              len8,
  input  par_mode_e         par,
  input  logic              stop2,
  output logic              line,
  output logic              busy
);
  localparam int CW = $clog2(OSR);
  localparam int FW = DATA_W + 4;
  localparam int NW = $clog2(FW + 1);

  logic [FW-1:0] sh_q, sh_d, frm;
  logic [NW-1:0] left_q, left_d, nb;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  // assemble the frame, first bit on the line in bit 0
  always_comb begin : build
    int pos;
    frm    = '1;
    frm[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < DATA_W - 1 || len8) frm[1+i] = data[i];
    pos = len8 ? DATA_W + 1 : DATA_W;
    if (par != PAR_NONE) begin
      frm[pos] = par_bit(par, data, len8);
      pos = pos + 1;
    end
    nb = NW'(pos + (stop2 ? 2 : 1));
  end

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (!run) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (!busy_q) begin
      if (load) begin
        sh_d   = frm;
        left_d = nb - NW'(1);
        cnt_d  = '0;
        busy_d = 1'b1;
      end
    end else if (tick) begin
      if (cnt_q == CW'(OSR - 1)) begin
        cnt_d = '0;
        if (left_q == '0) busy_d = 1'b0;
        else begin
          sh_d   = {1'b1, sh_q[FW-1:1]};
          left_d = left_q - NW'(1);
        end
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign line = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;
endmodule

// File: rtl/uart_xcvr_rx.sv
module uart_xcvr_rx
  import uart_xcvr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              act,
  input  logic              line,
  input  logic              len8,
  input  par_mode_e         par,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam int CW = $clog2(OSR);
  localparam int SW = DATA_W + 1;
  localparam int IW = $clog2(SW + 1);

  logic [1:0]    sync_q;
  logic          s;
  rx_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d, nbits;
  logic [SW-1:0] sh_q, sh_d, val;
  logic          pbit;

  assign s     = sync_q[1];
  assign nbits = IW'(len8 ? DATA_W : DATA_W - 1) + IW'(par != PAR_NONE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    if (!act) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
    end else if (tick) begin
      case (st_q)
        RX_IDLE: if (!s) begin
          st_d  = RX_START;
          cnt_d = '0;
        end
        RX_START: if (cnt_q == CW'(OSR / 2 - 1)) begin
          cnt_d = '0;
          idx_d = '0;
          st_d  = s ? RX_IDLE : RX_BITS;
        end else cnt_d = cnt_q + CW'(1);
        RX_BITS: if (cnt_q == CW'(OSR - 1)) begin
          cnt_d = '0;
          sh_d  = {s, sh_q[SW-1:1]};
          if (idx_q == nbits - IW'(1)) st_d = RX_STOP;
          else idx_d = idx_q + IW'(1);
        end else cnt_d = cnt_q + CW'(1);
        default: if (cnt_q == CW'(OSR - 1)) begin
          cnt_d = '0;
          st_d  = RX_IDLE;
        end else cnt_d = cnt_q + CW'(1);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], line};
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
    end
  end

  // collected bits sit at the top of sh_q; align them to bit 0
  assign val  = sh_q >> (SW - int'(nbits));
  assign data = len8 ? val[DATA_W-1:0] : {1'b0, val[DATA_W-2:0]};
  assign pbit = val[len8 ? DATA_W : DATA_W - 1];
  assign perr = (par != PAR_NONE) && (pbit != par_bit(par, data, len8));
  assign ferr = !s;
  assign done = act && tick && (st_q == RX_STOP) && (cnt_q == CW'(OSR - 1));
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              cfg_power,
  input  logic              cfg_tx_en,
  input  logic              cfg_rx_en,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_len8,
  input  logic              cfg_stop2,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_full,
  output logic              tx_line,
  input  logic              rx_line,
  input  logic              rd_err_stb,
  input  logic              rd_data_stb,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);
  logic [1:0]        rs_q;
  logic              rst_i_n;
  logic              tx_arm_q, rx_arm_q, tx_ok, rx_act;
  logic              wr_acc, load, tx_busy;
  logic              tx_full_q, tx_full_d;
  logic [DATA_W-1:0] tx_buf_q;
  logic              rx_done, rx_perr, rx_ferr, store, lost;
  logic [DATA_W-1:0] rx_word;
  logic              rx_valid_q, rx_valid_d;
  logic [DATA_W-1:0] rx_buf_q;
  logic              pe_q, pe_d, fe_q, fe_d, ov_q, ov_d;
  par_mode_e         par;

  assign par = par_mode_e'(cfg_parity);

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign tx_ok  = cfg_power && cfg_tx_en && tx_arm_q;
  assign rx_act = cfg_power && cfg_rx_en && rx_arm_q;
  assign wr_acc = wr_stb && tx_ok && !tx_full_q;
  assign load   = tx_full_q && tx_ok && !tx_busy;
  assign store  = rx_done && (!rx_valid_q || rd_data_stb);
  assign lost   = rx_done && rx_valid_q && !rd_data_stb;

  always_comb begin
    tx_full_d  = cfg_power && (wr_acc || (tx_full_q && !load));
    rx_valid_d = cfg_power && (store || (rx_valid_q && !rd_data_stb));
    pe_d = pe_q;
    fe_d = fe_q;
    ov_d = ov_q;
    if (rd_err_stb) begin
      pe_d = 1'b0;
      fe_d = 1'b0;
      ov_d = 1'b0;
    end
    if (store) begin
      pe_d = rx_perr;
      fe_d = rx_ferr;
    end
    if (lost) ov_d = 1'b1;
    if (!cfg_power) begin
      pe_d = 1'b0;
      fe_d = 1'b0;
      ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      tx_arm_q   <= 1'b0;
      rx_arm_q   <= 1'b0;
      tx_full_q  <= 1'b0;
      rx_valid_q <= 1'b0;
      pe_q       <= 1'b0;
      fe_q       <= 1'b0;
      ov_q       <= 1'b0;
    end else begin
      tx_arm_q   <= cfg_power && cfg_tx_en;
      rx_arm_q   <= cfg_power && cfg_rx_en;
      tx_full_q  <= tx_full_d;
      rx_valid_q <= rx_valid_d;
      pe_q       <= pe_d;
      fe_q       <= fe_d;
      ov_q       <= ov_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      tx_buf_q <= '0;
      rx_buf_q <= '0;
    end else begin
      if (wr_acc) tx_buf_q <= wr_data;
      if (store)  rx_buf_q <= rx_word;
    end
  end

  uart_xcvr_tx #(.OSR(OSR)) i_tx (
    .clk(clk), .rst_n(rst_i_n), .tick(baud_tick), .run(cfg_power),
    .load(load), .data(tx_buf_q), .len8(cfg_len8), .par(par),
    .stop2(cfg_stop2), .line(tx_line), .busy(tx_busy)
  );

  uart_xcvr_rx #(.OSR(OSR)) i_rx (
    .clk(clk), .rst_n(rst_i_n), .tick(baud_tick), .act(rx_act),
    .line(rx_line), .len8(cfg_len8), .par(par), .done(rx_done),
    .data(rx_word), .perr(rx_perr), .ferr(rx_ferr)
  );

  assign tx_full     = tx_full_q;
  assign rx_valid    = rx_valid_q;
  assign rx_data     = rx_buf_q;
  assign err_parity  = pe_q;
  assign err_frame   = fe_q;
  assign err_overrun = ov_q;
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_power,
  input logic       cfg_tx_en,
  input logic       wr_stb,
  input logic       tx_full,
  input logic       tx_line,
  input logic [7:0] tx_buf_q,
  input logic       rx_done,
  input logic       rx_valid,
  input logic       rd_data_stb,
  input logic       rd_err_stb,
  input logic [7:0] rx_data,
  input logic       err_parity,
  input logic       err_frame,
  input logic       err_overrun
);
  // R2
  first_en_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_power && $rose(cfg_tx_en) && wr_stb && !tx_full |=> !tx_full);

  // R3
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && wr_stb |=> $stable(tx_buf_q));

  // R12
  power_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_power |=> tx_line && !tx_full);

  // R9
  overrun_keeps_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_valid && !rd_data_stb |=> err_overrun && $stable(rx_data));

  // R10
  err_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_stb && !rx_done |=> !err_parity && !err_frame && !err_overrun);
endmodule

bind uart_xcvr uart_xcvr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_power(cfg_power), .cfg_tx_en(cfg_tx_en),
  .wr_stb(wr_stb), .tx_full(tx_full), .tx_line(tx_line), .tx_buf_q(tx_buf_q),
  .rx_done(rx_done), .rx_valid(rx_valid), .rd_data_stb(rd_data_stb),
  .rd_err_stb(rd_err_stb), .rx_data(rx_data), .err_parity(err_parity),
  .err_frame(err_frame), .err_overrun(err_overrun)
);

// File: tb/test_uart_xcvr.sv
module test_uart_xcvr;
  logic       clk = 1'b0;
  logic       rst_n, power, tx_en, rx_en, len8, stop2, wr_stb, rd_err, rd_dat;
  logic [1:0] par;
  logic [7:0] wdata, rx_data;
  logic       tx_full, tx_line, rx_valid, pe, fe, ov;
  logic       loop_en, drv_rx, rx_in;
  int         checks = 0, fails = 0;
  bit         finished = 0;

  always #10 clk = ~clk;
  assign rx_in = loop_en ? tx_line : drv_rx;

  uart_xcvr i_uart_xcvr (
    .clk(clk), .rst_n(rst_n), .baud_tick(1'b1), .cfg_power(power),
    .cfg_tx_en(tx_en), .cfg_rx_en(rx_en), .cfg_parity(par), .cfg_len8(len8),
    .cfg_stop2(stop2), .wr_stb(wr_stb), .wr_data(wdata), .tx_full(tx_full),
    .tx_line(tx_line), .rx_line(rx_in), .rd_err_stb(rd_err), .rd_data_stb(rd_dat),
    .rx_valid(rx_valid), .rx_data(rx_data), .err_parity(pe), .err_frame(fe),
    .err_overrun(ov)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask(logic [7:0] d, logic l8);
    return l8 ? d : {1'b0, d[6:0]};
  endfunction

  function automatic logic exp_par(logic [1:0] p, logic [7:0] d, logic l8);
    int ones = $countones(mask(d, l8));
    if (p == 2'b10) return (ones % 2) == 0;
    if (p == 2'b11) return (ones % 2) == 1;
    return 1'b0;
  endfunction

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic [7:0] d);
    wdata = d; wr_stb = 1'b1; nclk(1); wr_stb = 1'b0;
  endtask

  task automatic send_bit(logic b);
    drv_rx = b; nclk(16);
  endtask

  // drives one frame on drv_rx using the current settings
  task automatic send_frame(logic [7:0] d, logic bad_par, logic stop_v, int idle);
    send_bit(1'b0);
    for (int i = 0; i < (len8 ? 8 : 7); i++) send_bit(d[i]);
    if (par != 2'b00) send_bit(exp_par(par, d, len8) ^ bad_par);
    send_bit(stop_v);
    drv_rx = 1'b1;
    nclk(16 * idle);
  endtask

  task automatic wait_rx(string req);
    int n = 0;
    while (!rx_valid && n < 600) begin nclk(1); n++; end
    chk(req, {31'd0, rx_valid}, 32'd1);
  endtask

  task automatic read_all(output logic [7:0] d, output logic [2:0] flags);
    d = rx_data; flags = {pe, fe, ov};
    rd_err = 1'b1; nclk(1); rd_err = 1'b0;
    rd_dat = 1'b1; nclk(1); rd_dat = 1'b0;
  endtask

  task automatic check_tx_frame(logic [7:0] d);
    int n = 0;
    while (tx_line && n < 100) begin nclk(1); n++; end
    nclk(8);
    chk("R4 start", {31'd0, tx_line}, 32'd0);
    for (int i = 0; i < (len8 ? 8 : 7); i++) begin
      nclk(16); chk("R4 data", {31'd0, tx_line}, {31'd0, d[i]});
    end
    if (par != 2'b00) begin
      nclk(16); chk("R5 parity bit", {31'd0, tx_line}, {31'd0, exp_par(par, d, len8)});
    end
    for (int i = 0; i < (stop2 ? 2 : 1); i++) begin
      nclk(16); chk("R4 stop", {31'd0, tx_line}, 32'd1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic [2:0] fl;
    void'($urandom(32'd1234));
    rst_n = 0; power = 0; tx_en = 0; rx_en = 0; par = 0; len8 = 1; stop2 = 0;
    wr_stb = 0; wdata = 0; rd_err = 0; rd_dat = 0; loop_en = 0; drv_rx = 1;
    nclk(3);
    chk("R1 reset outputs", {26'd0, tx_line, tx_full, rx_valid, pe, fe, ov}, 32'h20);
    rst_n = 1; nclk(3);
    chk("R1 after release", {26'd0, tx_line, tx_full, rx_valid, pe, fe, ov}, 32'h20);

    // R2: write in the same clock as enable is dropped
    power = 1; nclk(2);
    tx_en = 1; write(8'h55);
    chk("R2 first-clock write dropped", {31'd0, tx_full}, 32'd0);
    nclk(40);
    chk("R2 nothing sent", {31'd0, tx_line}, 32'd1);

    // R3/R4/R5: directed frame on the line
    par = 2'b11; len8 = 1; stop2 = 1;
    write(8'hA5);
    chk("R3 full after write", {31'd0, tx_full}, 32'd1);
    nclk(1);
    chk("R3 full clears on load", {31'd0, tx_full}, 32'd0);
    check_tx_frame(8'hA5);
    par = 2'b01; len8 = 0; stop2 = 0; nclk(20);
    write(8'hC3); check_tx_frame(8'hC3);
    par = 2'b10; len8 = 1; nclk(20);
    write(8'h07); check_tx_frame(8'h07);

    // R3: write while full never reaches the line
    par = 2'b00; len8 = 1; stop2 = 0; nclk(40);
    loop_en = 1; rx_en = 1; nclk(4);
    write(8'h11); nclk(2);
    write(8'h22);
    write(8'h33);
    chk("R3 still full", {31'd0, tx_full}, 32'd1);
    wait_rx("R3 first rx"); read_all(d, fl);
    chk("R3 first char", {24'd0, d}, 32'h11);
    wait_rx("R3 second rx"); read_all(d, fl);
    chk("R3 second char", {24'd0, d}, 32'h22);
    nclk(400);
    chk("R3 third dropped", {31'd0, rx_valid}, 32'd0);

    // R5/R6: random loopback
    for (int it = 0; it < 24; it++) begin
      par = 2'($urandom); len8 = 1'($urandom); stop2 = 1'($urandom);
      d2 = 8'($urandom);
      nclk(2);
      write(d2);
      wait_rx("R6 loopback rx"); read_all(d, fl);
      chk("R6 loopback data", {24'd0, d}, {24'd0, mask(d2, len8)});
      chk("R5 loopback no errors", {29'd0, fl}, 32'd0);
      chk("R6 valid cleared", {31'd0, rx_valid}, 32'd0);
      nclk(60);
    end

    // R7: parity errors per mode
    loop_en = 0; len8 = 1; stop2 = 0;
    for (int m = 1; m < 4; m++) begin
      par = 2'(m); d2 = 8'($urandom);
      send_frame(d2, 1'b1, 1'b1, 1);
      wait_rx("R7 rx"); read_all(d, fl);
      chk("R7 bad parity flagged", {29'd0, fl}, 32'b100);
      chk("R7 data kept", {24'd0, d}, {24'd0, d2});
    end

    // R8: low stop bit
    par = 2'b00;
    send_frame(8'h5A, 1'b0, 1'b0, 1);
    wait_rx("R8 rx"); read_all(d, fl);
    chk("R8 framing error", {29'd0, fl}, 32'b010);

    // R8: two stop bits configured, single stop bits received back to back
    stop2 = 1; len8 = 0;
    fork
      begin send_frame(8'h2B, 1'b0, 1'b1, 0); send_frame(8'h4C, 1'b0, 1'b1, 1); end
      begin
        wait_rx("R8 a"); read_all(d, fl);
        chk("R8 first of pair", {21'd0, fl, d}, 32'h02B);
        wait_rx("R8 b"); read_all(d, fl);
        chk("R8 second of pair", {21'd0, fl, d}, 32'h04C);
      end
    join

    // R9: overrun keeps the older character
    stop2 = 0; len8 = 1;
    send_frame(8'h81, 1'b0, 1'b1, 1);
    send_frame(8'h7E, 1'b0, 1'b1, 1);
    chk("R9 overrun set", {31'd0, ov}, 32'd1);
    read_all(d, fl);
    chk("R9 old data kept", {24'd0, d}, 32'h81);
    chk("R10 flags cleared", {29'd0, pe, fe, ov}, 32'd0);

    // R10: flags follow the buffered character
    par = 2'b11;
    send_frame(8'h3C, 1'b1, 1'b1, 1);
    chk("R10 parity of first", {31'd0, pe}, 32'd1);
    rd_dat = 1'b1; nclk(1); rd_dat = 1'b0;
    send_frame(8'h3D, 1'b0, 1'b1, 1);
    chk("R10 replaced by new char", {31'd0, pe}, 32'd0);
    read_all(d, fl);

    // R11: enable raised on a low line
    par = 2'b00; rx_en = 0; nclk(4);
    drv_rx = 1'b0; rx_en = 1;
    send_frame(8'h96, 1'b0, 1'b1, 1);
    wait_rx("R11 rx"); read_all(d, fl);
    chk("R11 frame from low line", {21'd0, fl, d}, 32'h096);

    // R12: power off mid-frame, then re-enable latency
    write(8'hF0); nclk(50);
    power = 0; nclk(1);
    chk("R12 line idle", {30'd0, tx_line, tx_full}, 32'b10);
    nclk(30);
    chk("R12 stays idle", {31'd0, tx_line}, 32'd1);
    power = 1; write(8'h0F);
    chk("R12 first write after power dropped", {31'd0, tx_full}, 32'd0);
    write(8'h0F);
    chk("R12 later write accepted", {31'd0, tx_full}, 32'd1);
    nclk(300);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule